// File: doc/BRIEF.md
# UART register front end on APB

This block is the software-visible face of a UART. An APB slave exposes a small window of 32-bit registers: a data port, a read-only status word and a control word. Incoming bytes reach the block on a valid/ready byte stream and are buffered in a receive queue. Software drains that queue by reading the data port. Bytes that software writes to the data port go out at once on a second valid/ready byte stream. There is no transmit buffering. A single interrupt line gives a one-cycle pulse on receive and transmit events, and each direction has its own enable.

Serial framing, baud generation, parity, flow control, loopback and FIFO debugging belong elsewhere. The matching control bits are stored and read back but have no effect. Back-pressure rules apply to both streams. On the receive side, `rx_ready` is low only while the queue is full, and a byte counts as transferred in any cycle where `rx_valid` and `rx_ready` are both high. On the transmit side, `tx_valid` is high only during the access phase of a data-port write. If `tx_ready` is low in that cycle, the byte is lost, because the APB access cannot be stalled.

Top module: `uart_apb_frontend`

## Requirements
- R1: After reset, control reads 0, status reads 0x0000_0006, the receive queue is empty, `rx_ready` is 1 and `irq` is 0.
- R2: The control word at offset 0x08 stores all 32 written bits and reads them back unchanged. Bit 0 is receive enable, bit 1 is transmit enable, bit 2 is receive interrupt enable and bit 3 is transmit interrupt enable. No other control bit has any effect.
- R3: A byte accepted on the receive stream is queued only while control bit 0 is 1. While bit 0 is 0, an accepted byte is discarded.
- R4: A read of the data port returns the oldest queued byte in bits 7:0 and removes it, so bytes come out in arrival order. A read while the queue is empty returns 0 and changes nothing.
- R5: The status word at offset 0x04 reads as follows. Bit 0 is 1 while the queue is non-empty. Bits 1 and 2 always read 1. Bit 8 is 1 while the fill level is at least half the depth. Bit 10 is 1 while the queue is full. All other bits read 0.
- R6: `rx_ready` is 0 exactly while the queue holds DEPTH bytes.
- R7: An APB write to the data port with control bit 1 set raises `tx_valid` during its access phase, with `tx_data` equal to write-data bits 7:0. With bit 1 clear, `tx_valid` stays 0.
- R8: `irq` is high for one cycle, the cycle after a byte is queued while control bit 2 is set, or the cycle after a completed transmit handshake while control bit 3 is set. It is 0 at all other times.
- R9: Offset 0x03 behaves as the data port for both reads and writes.
- R10: Writes to the status offset, offset 0x0C, offset 0x10 or any undecoded offset change nothing. Reads of those offsets other than status return 0. Only address bits 7:0 are decoded.
- R11: A transmit write made while `tx_ready` is 0 is dropped. It produces no interrupt and leaves the status word unchanged.
- R12: `pready` is always 1 and `pslverr` is always 0.
- R13: Side effects (control update, queue pop, transmit) happen only in the access phase (`psel` and `penable` both high), and once per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| pslverr | output | 1 | APB error, always 0 |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Receive stream ready |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmit stream ready |
| irq | output | 1 | Interrupt pulse |

## Verification
The properties assume the APB master follows the protocol. An access phase is always preceded by a setup phase with the same address and direction, and `psel` is never dropped in the middle of a transfer. They also assume `rx_data` is stable whenever `rx_valid` is high. The bench drives every transfer through a single task that always issues a setup phase followed by an access phase, and it changes the streams only on falling edges. It fills the queue to its depth with arithmetically generated bytes, then drains it through both data offsets, and sweeps the control word with a walking one.

// File: rtl/uart_apb_pkg.sv
package uart_apb_pkg;
  localparam int unsigned DEC_W = 8;

  localparam logic [DEC_W-1:0] OFS_DATA     = 8'h00;
  localparam logic [DEC_W-1:0] OFS_DATA_ALT = 8'h03;
  localparam logic [DEC_W-1:0] OFS_STAT     = 8'h04;
  localparam logic [DEC_W-1:0] OFS_CTRL     = 8'h08;

  // control bit positions that carry behaviour
  localparam int unsigned CB_RX_ON  = 0;
  localparam int unsigned CB_TX_ON  = 1;
  localparam int unsigned CB_RX_IRQ = 2;
  localparam int unsigned CB_TX_IRQ = 3;

  // status bit positions
  localparam int unsigned SB_AVAIL   = 0;
  localparam int unsigned SB_TSH_MT  = 1;
  localparam int unsigned SB_TQ_MT   = 2;
  localparam int unsigned SB_RQ_HALF = 8;
  localparam int unsigned SB_RQ_FULL = 10;

  typedef enum logic [1:0] {
    RSEL_DATA,
    RSEL_STAT,
    RSEL_CTRL,
    RSEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/uab_decode.sv
module uab_decode
  import uart_apb_pkg::*;
(
  input  logic [DEC_W-1:0] offs,
  output reg_sel_e         sel
);
  always_comb begin
    unique case (offs)
      OFS_DATA, OFS_DATA_ALT: sel = RSEL_DATA;
      OFS_STAT:               sel = RSEL_STAT;
      OFS_CTRL:               sel = RSEL_CTRL;
      default:                sel = RSEL_NONE;
    endcase
  end
endmodule

// File: rtl/uab_rx_fifo.sv
module uab_rx_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CNT_W-1:0] fill,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  wire do_push = push && !full;
  wire do_pop  = pop && !empty;

  assign full  = (fill == CNT_W'(DEPTH));
  assign empty = (fill == '0);
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   fill <= fill + CNT_W'(1);
        2'b01:   fill <= fill - CNT_W'(1);
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/uab_irq_pulse.sv
module uab_irq_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_evt,
  input  logic rx_en,
  input  logic tx_evt,
  input  logic tx_en,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= (rx_evt && rx_en) || (tx_evt && tx_en);
  end
endmodule

// File: rtl/uart_apb_frontend.sv
module uart_apb_frontend
  import uart_apb_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned RX_DEPTH = 16,
  localparam int unsigned CNT_W   = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  output logic              irq
);
  localparam logic [CNT_W-1:0] HALF_MARK = CNT_W'(RX_DEPTH / 2);

  reg_sel_e         sel;
  logic [31:0]      ctrl_q;
  logic [31:0]      status;
  logic [7:0]       q_head;
  logic [CNT_W-1:0] fill;
  logic             q_full, q_empty;
  logic             acc, rd_acc, wr_acc, rx_take, rx_store, rd_pop, tx_fire;

  uab_decode u_dec (.offs(paddr[DEC_W-1:0]), .sel(sel));

  assign acc    = psel && penable;
  assign rd_acc = acc && !pwrite;
  assign wr_acc = acc && pwrite;

  // receive stream: always drained unless full, stored only when enabled
  assign rx_ready = !q_full;
  assign rx_take  = rx_valid && rx_ready;
  assign rx_store = rx_take && ctrl_q[CB_RX_ON];
  assign rd_pop   = rd_acc && (sel == RSEL_DATA) && !q_empty;

  uab_rx_fifo #(.DEPTH(RX_DEPTH), .WIDTH(8)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rx_store),
    .din   (rx_data),
    .pop   (rd_pop),
    .dout  (q_head),
    .fill  (fill),
    .full  (q_full),
    .empty (q_empty)
  );

  // transmit stream: unbuffered, lives only in the access phase
  assign tx_valid = wr_acc && (sel == RSEL_DATA) && ctrl_q[CB_TX_ON];
  assign tx_data  = pwdata[7:0];
  assign tx_fire  = tx_valid && tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)                             ctrl_q <= '0;
    else if (wr_acc && (sel == RSEL_CTRL))  ctrl_q <= pwdata;
  end

  always_comb begin
    status               = '0;
    status[SB_AVAIL]     = !q_empty;
    status[SB_TSH_MT]    = 1'b1;
    status[SB_TQ_MT]     = 1'b1;
    status[SB_RQ_HALF]   = (fill >= HALF_MARK);
    status[SB_RQ_FULL]   = q_full;
  end

  always_comb begin
    prdata = '0;
    if (rd_acc) begin
      unique case (sel)
        RSEL_DATA: prdata = q_empty ? 32'h0 : {24'h0, q_head};
        RSEL_STAT: prdata = status;
        RSEL_CTRL: prdata = ctrl_q;
        default:   prdata = '0;
      endcase
    end
  end

  uab_irq_pulse u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .rx_evt (rx_store),
    .rx_en  (ctrl_q[CB_RX_IRQ]),
    .tx_evt (tx_fire),
    .tx_en  (ctrl_q[CB_TX_IRQ]),
    .irq    (irq)
  );

  assign pready  = 1'b1;
  assign pslverr = 1'b0;
endmodule

// File: rtl/uab_checker.sv
module uab_checker #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             psel,
  input logic             penable,
  input logic             pwrite,
  input logic             pready,
  input logic             pslverr,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             irq,
  input logic [31:0]      ctrl_q,
  input logic [CNT_W-1:0] fill
);
  AST_BUS_OK: assert property (@(posedge clk) disable iff (!rst_n)
    pready && !pslverr);  // R12

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == CNT_W'(DEPTH)) |-> !rx_ready);  // R6

  AST_TX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (psel && penable && pwrite && ctrl_q[1]));  // R7

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past((rx_valid && rx_ready && ctrl_q[0] && ctrl_q[2]) ||
                  (tx_valid && tx_ready && ctrl_q[3])));  // R8

  AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == $past(fill)) || (fill == $past(fill) + CNT_W'(1)) ||
    (fill + CNT_W'(1) == $past(fill)));  // R4

  AST_RX_OFF_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[0] |=> (fill <= $past(fill)));  // R3

  AST_IDLE_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(psel && penable) |=> $stable(ctrl_q));  // R13
endmodule

bind uart_apb_frontend uab_checker #(.DEPTH(RX_DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .psel     (psel),
  .penable  (penable),
  .pwrite   (pwrite),
  .pready   (pready),
  .pslverr  (pslverr),
  .rx_valid (rx_valid),
  .rx_ready (rx_ready),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .irq      (irq),
  .ctrl_q   (ctrl_q),
  .fill     (fill)
);

// File: tb/test_uart_apb_frontend.sv
module test_uart_apb_frontend;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b1;
  logic        irq;

  int checks = 0;
  int errors = 0;

  logic [31:0] seen_rd;
  logic        seen_txv, seen_irq, seen_rdy;
  logic [7:0]  seen_txd;

  always #10 clk = ~clk;

  uart_apb_frontend #(.ADDR_W(12), .RX_DEPTH(DEPTH)) i_uart_apb_frontend (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    #1;
    seen_rd = prdata; seen_txv = tx_valid; seen_txd = tx_data;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
    seen_irq = irq;
  endtask

  task automatic setup_only(input logic wr, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge clk);
    @(negedge clk);
    psel = 1'b0;
  endtask

  task automatic send_rx(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    #1 seen_rdy = rx_ready;
    @(negedge clk);
    rx_valid = 1'b0;
    seen_irq = irq;
  endtask

  function automatic logic [31:0] exp_stat(input int n);
    return 32'h6 | ((n > 0) ? 32'h1 : 32'h0) | ((n >= DEPTH/2) ? 32'h100 : 32'h0)
                 | ((n == DEPTH) ? 32'h400 : 32'h0);
  endfunction

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) & 8'hFF);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 and R12 reset state
    #1;
    chk("R1 rx_ready", {31'b0, rx_ready}, 32'h1);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R12 pready/pslverr", {30'b0, pready, pslverr}, 32'h2);
    xfer(1'b0, 12'h004, 0); chk("R1 status", seen_rd, 32'h6);
    xfer(1'b0, 12'h008, 0); chk("R1 control", seen_rd, 32'h0);

    // R2 walking one over the control word
    for (int b = 0; b < 32; b++) begin
      xfer(1'b1, 12'h008, 32'h1 << b);
      xfer(1'b0, 12'h008, 0);
      chk("R2 ctrl readback", seen_rd, 32'h1 << b);
    end
    // unused control bits set, receive/transmit enables clear: no effect
    xfer(1'b1, 12'h008, 32'h8000_1FF0);

    // R3 receive disabled: bytes discarded
    for (int i = 0; i < 3; i++) begin
      send_rx(pat(i));
      chk("R3 rx_ready while off", {31'b0, seen_rdy}, 32'h1);
    end
    xfer(1'b0, 12'h004, 0); chk("R3 nothing queued", seen_rd, 32'h6);
    xfer(1'b0, 12'h000, 0); chk("R3 empty data", seen_rd, 32'h0);

    // R5/R6 fill to depth with receive on, receive irq off
    xfer(1'b1, 12'h008, 32'h1);
    for (int i = 0; i < DEPTH; i++) begin
      send_rx(pat(i));
      chk("R6 ready before full", {31'b0, seen_rdy}, 32'h1);
      chk("R8 no irq when disabled", {31'b0, seen_irq}, 32'h0);
      xfer(1'b0, 12'h004, 0);
      chk("R5 status filling", seen_rd, exp_stat(i + 1));
    end
    #1 chk("R6 ready low when full", {31'b0, rx_ready}, 32'h0);
    // R13 setup-only read must not pop, setup-only write must not store
    setup_only(1'b0, 12'h000, 0);
    setup_only(1'b1, 12'h008, 32'hFFFF_FFFF);
    xfer(1'b0, 12'h004, 0); chk("R13 no pop in setup", seen_rd, exp_stat(DEPTH));
    xfer(1'b0, 12'h008, 0); chk("R13 ctrl unchanged", seen_rd, 32'h1);

    // R4/R9 drain alternating offsets 0x00 and 0x03
    for (int i = 0; i < DEPTH; i++) begin
      xfer(1'b0, (i % 2 == 0) ? 12'h000 : 12'h003, 0);
      chk((i % 2 == 0) ? "R4 pop order" : "R9 pop at alias", seen_rd, {24'h0, pat(i)});
      xfer(1'b0, 12'h004, 0);
      chk("R5 status draining", seen_rd, exp_stat(DEPTH - 1 - i));
    end
    xfer(1'b0, 12'h000, 0); chk("R4 empty read zero", seen_rd, 32'h0);
    xfer(1'b0, 12'h004, 0); chk("R4 empty read no effect", seen_rd, 32'h6);

    // R8 receive interrupt pulse
    xfer(1'b1, 12'h008, 32'h5);
    send_rx(8'h3C);
    chk("R8 rx irq pulse", {31'b0, seen_irq}, 32'h1);
    @(negedge clk); chk("R8 rx irq one cycle", {31'b0, irq}, 32'h0);
    xfer(1'b0, 12'h003, 0); chk("R4 single byte", seen_rd, 32'h3C);

    // R7 transmit disabled
    xfer(1'b1, 12'h008, 32'h8);
    xfer(1'b1, 12'h000, 32'h55);
    chk("R7 no tx when off", {31'b0, seen_txv}, 32'h0);
    chk("R8 no tx irq when off", {31'b0, seen_irq}, 32'h0);

    // R7/R8/R9 transmit enabled
    xfer(1'b1, 12'h008, 32'hA);
    for (int i = 0; i < 4; i++) begin
      logic [31:0] w;
      w = 32'h1234_5600 | 32'(pat(i + 20));
      xfer(1'b1, (i % 2 == 0) ? 12'h000 : 12'h003, w);
      chk("R7 tx valid", {31'b0, seen_txv}, 32'h1);
      chk((i % 2 == 0) ? "R7 tx data" : "R9 tx data at alias", {24'h0, seen_txd}, {24'h0, pat(i + 20)});
      chk("R8 tx irq pulse", {31'b0, seen_irq}, 32'h1);
    end
    @(negedge clk); chk("R8 tx irq one cycle", {31'b0, irq}, 32'h0);

    // R11 transmit not ready: dropped
    tx_ready = 1'b0;
    xfer(1'b1, 12'h000, 32'h77);
    chk("R11 no irq on drop", {31'b0, seen_irq}, 32'h0);
    xfer(1'b0, 12'h004, 0); chk("R11 status unchanged", seen_rd, 32'h6);
    tx_ready = 1'b1;

    // R10 ignored writes and zero reads
    xfer(1'b1, 12'h004, 32'hFFFF_FFFF);
    xfer(1'b1, 12'h00C, 32'hFFFF_FFFF);
    xfer(1'b1, 12'h010, 32'hFFFF_FFFF);
    xfer(1'b1, 12'h001, 32'hFFFF_FFFF);
    xfer(1'b0, 12'h004, 0); chk("R10 status write ignored", seen_rd, 32'h6);
    xfer(1'b0, 12'h008, 0); chk("R10 ctrl untouched", seen_rd, 32'hA);
    xfer(1'b0, 12'h00C, 0); chk("R10 scaler reads 0", seen_rd, 32'h0);
    xfer(1'b0, 12'h010, 0); chk("R10 debug reads 0", seen_rd, 32'h0);
    xfer(1'b0, 12'h002, 0); chk("R10 unknown reads 0", seen_rd, 32'h0);
    xfer(1'b1, 12'h308, 32'h0000_00C1);
    xfer(1'b0, 12'h008, 0); chk("R10 low bits decoded", seen_rd, 32'hC1);

    #1 chk("R12 bus always ok", {30'b0, pready, pslverr}, 32'h2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule